// File: doc/BRIEF.md
# Control Register and Trap Entry Unit

This unit keeps the processor's control and status registers and executes the three instructions that touch them: the register-read instruction, the register-write instruction and the software trap. It also merges fault requests from the execute stage (illegal operation, division by zero) with the faults it finds itself. When any fault is accepted, it reports the faulting instruction's address, a cause code and the handler address. It saves and clears the interrupt enable, and names the general register that must receive the return address. Return strobes from the branch unit bring the saved enable back.

The unit sits beside the execute stage and sees one decoded instruction word per cycle, together with its address and the value of its source register. Every result is registered, so a read result or a trap indication appears one cycle after the instruction is presented. The interrupt-enable output follows a register write by the same single cycle, so the next instruction can already be interrupted. Handler bases keep their low eight bits at zero, which lets the cause code be added in as an offset of 32 bytes per cause. The breakpoint trap uses the debug base and its own saved-enable slot. Every other cause uses the normal base.

Top module: `csr_exc_unit`

## Requirements
- R1: While reset is held and on the first cycle after its release, rdValid, excTaken and intEnable are 0, and the enable register reads back as 0.
- R2: An instruction with opcode 36 in bits 31:26 reads the register whose number is in bits 25:21 and returns it one cycle later with rdValid=1 and rdDest taken from bits 15:11. The readable numbers are 0 enable, 1 mask, 2 pending, 5 cycle count, 6 configuration, 7 handler base, 8 debug control, 9 debug handler base, 14 and 15 debug channel.
- R3: A read of number 3 or 4 (cache invalidate), 16 to 19 (breakpoints), 24 to 27 (watchpoints) or any unassigned number returns zero.
- R4: An instruction with opcode 52 writes srcData to the register numbered in bits 25:21, visible one cycle later. A write to number 0 drives intEnable from srcData bit 0 on the next cycle.
- R5: The cycle count (number 5) adds one on every clock. Writes to it and to the configuration (number 6) change nothing. The configuration reads {20'b0, watchpoint count[3:0], breakpoint count[3:0], sign-extend, shifter, divider, multiplier}.
- R6: Bits 7:0 of both handler bases (numbers 7 and 9) always read as zero.
- R7: A write to breakpoint slot n (number 16+n) or watchpoint slot n (number 24+n) is stored on brkAddrs/wchAddrs bits n*32+31:n*32 when n is below the configured count. Otherwise it raises cause 2 and stores nothing.
- R8: Opcode 43 traps on bits 4:0. A value of 2 gives a breakpoint (cause 1), 7 gives a system call (cause 7), and any other value gives cause 2.
- R9: One cycle after a faulting instruction, excTaken=1, excPc equals that instruction's instPc, and excTarget equals the base plus cause*32. The base is the debug handler base and raIdx is 31 for cause 1. For every other cause the base is the handler base and raIdx is 30.
- R10: The enable register holds bit 0 live enable, bit 1 exception-saved copy and bit 2 breakpoint-saved copy. On entry the live bit is copied to bit 2 (cause 1) or bit 1 (all others), and the live bit is cleared.
- R11: retExc copies bit 1 into the live bit and retBrk copies bit 2. A same-cycle fault or write to the enable register takes precedence over either strobe.
- R12: excIllegal outranks excDivZero (cause 5), which outranks faults found by the unit. A faulting instruction's own read result and register write are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| instValid | input | 1 | instWord holds an instruction this cycle |
| instWord | input | 32 | Instruction word |
| instPc | input | 32 | Address of the instruction |
| srcData | input | 32 | Source register value for a register write |
| excIllegal | input | 1 | Execute stage reports an illegal operation for this instruction |
| excDivZero | input | 1 | Execute stage reports division by zero for this instruction |
| retExc | input | 1 | Return from an exception handler |
| retBrk | input | 1 | Return from a breakpoint handler |
| rdValid | output | 1 | rdData holds a read result |
| rdDest | output | 5 | Destination general register of the read |
| rdData | output | 32 | Read result |
| excTaken | output | 1 | A fault was accepted |
| excCause | output | 3 | Cause code |
| excPc | output | 32 | Address of the faulting instruction, also the return address |
| excTarget | output | 32 | Handler address |
| raIdx | output | 5 | General register that receives excPc |
| intEnable | output | 1 | Live interrupt enable |
| brkAddrs | output | NUM_BP*32 | Breakpoint slot contents |
| wchAddrs | output | NUM_WP*32 | Watchpoint slot contents |

## Verification
The properties assume that excIllegal and excDivZero matter only while instValid is high. They also assume that a return strobe never needs to win against a fault or an enable write in the same cycle. The stimulus drives fault requests only alongside a valid instruction and raises return strobes only on cycles with no instruction. It holds every input at zero during reset, so the cycle after release has no history to interpret. Handler bases are programmed before the first trap, so every expected handler address is a known sum.

// File: rtl/csr_exc_pkg.sv
package csr_exc_pkg;

  localparam int XLEN = 32;

  localparam logic [5:0] OPC_RDREG = 6'd36;
  localparam logic [5:0] OPC_WRREG = 6'd52;
  localparam logic [5:0] OPC_TRAP  = 6'd43;

  localparam logic [4:0] TRAP_BRK = 5'd2;
  localparam logic [4:0] TRAP_SYS = 5'd7;

  localparam logic [4:0] REG_ENABLE  = 5'd0;
  localparam logic [4:0] REG_MASK    = 5'd1;
  localparam logic [4:0] REG_PEND    = 5'd2;
  localparam logic [4:0] REG_CYCLES  = 5'd5;
  localparam logic [4:0] REG_CONFIG  = 5'd6;
  localparam logic [4:0] REG_HBASE   = 5'd7;
  localparam logic [4:0] REG_DBGCTL  = 5'd8;
  localparam logic [4:0] REG_DHBASE  = 5'd9;
  localparam logic [4:0] REG_CHANTX  = 5'd14;
  localparam logic [4:0] REG_CHANRX  = 5'd15;
  localparam logic [4:0] REG_BRK0    = 5'd16;
  localparam logic [4:0] REG_WCH0    = 5'd24;

  localparam logic [2:0] CAUSE_BRK = 3'd1;
  localparam logic [2:0] CAUSE_ILL = 3'd2;
  localparam logic [2:0] CAUSE_DIV = 3'd5;
  localparam logic [2:0] CAUSE_SYS = 3'd7;

  typedef struct packed {
    logic       rdEn;
    logic [4:0] rdSel;
    logic [4:0] rdDest;
    logic       wrEn;
    logic [4:0] wrSel;
    logic       excEn;
    logic [2:0] excCause;
    logic       excDebug;
    logic       retExc;
    logic       retBrk;
  } ctrlStrobe_t;

endpackage

// File: rtl/csr_exc_ctrl.sv
module csr_exc_ctrl
  import csr_exc_pkg::*;
#(
  parameter int NUM_BP = 2,
  parameter int NUM_WP = 1
) (
  input  logic             instValid,
  input  logic [XLEN-1:0]  instWord,
  input  logic             excIllegal,
  input  logic             excDivZero,
  input  logic             retExc,
  input  logic             retBrk,
  output ctrlStrobe_t      strb
);

  logic [5:0] opc;
  logic [4:0] regNum;
  logic [4:0] trapCode;
  logic [4:0] destIdx;
  logic       unusedFields;

  assign opc      = instWord[31:26];
  assign regNum   = instWord[25:21];
  assign destIdx  = instWord[15:11];
  assign trapCode = instWord[4:0];
  assign unusedFields = ^{instWord[20:16], instWord[10:5]};

  logic isRd, isWr, isTrap;
  logic brkSlot, wchSlot, slotBad;
  logic [31:0] slotIdx;

  assign isRd    = instValid && (opc == OPC_RDREG);
  assign isWr    = instValid && (opc == OPC_WRREG);
  assign isTrap  = instValid && (opc == OPC_TRAP);
  assign brkSlot = (regNum[4:2] == REG_BRK0[4:2]);
  assign wchSlot = (regNum[4:2] == REG_WCH0[4:2]);
  assign slotIdx = 32'(regNum[1:0]);
  assign slotBad = isWr && ((brkSlot && (slotIdx >= 32'(NUM_BP))) ||
                            (wchSlot && (slotIdx >= 32'(NUM_WP))));

  logic       faultEn;
  logic [2:0] faultCause;

  always_comb begin
    faultEn    = 1'b1;
    faultCause = CAUSE_ILL;
    if (instValid && excIllegal) begin
      faultCause = CAUSE_ILL;
    end else if (instValid && excDivZero) begin
      faultCause = CAUSE_DIV;
    end else if (slotBad) begin
      faultCause = CAUSE_ILL;
    end else if (isTrap) begin
      case (trapCode)
        TRAP_BRK: faultCause = CAUSE_BRK;
        TRAP_SYS: faultCause = CAUSE_SYS;
        default:  faultCause = CAUSE_ILL;
      endcase
    end else begin
      faultEn = 1'b0;
    end
  end

  always_comb begin
    strb          = '0;
    strb.rdEn     = isRd && !faultEn;
    strb.rdSel    = regNum;
    strb.rdDest   = destIdx;
    strb.wrEn     = isWr && !faultEn;
    strb.wrSel    = regNum;
    strb.excEn    = faultEn;
    strb.excCause = faultCause;
    strb.excDebug = faultEn && (faultCause == CAUSE_BRK);
    strb.retExc   = retExc;
    strb.retBrk   = retBrk;
  end

endmodule

// File: rtl/csr_exc_dp.sv
module csr_exc_dp
  import csr_exc_pkg::*;
#(
  parameter int          NUM_BP    = 2,
  parameter int          NUM_WP    = 1,
  parameter logic [31:0] CFG_VALUE = 32'h0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strb,
  input  logic [XLEN-1:0]        instPc,
  input  logic [XLEN-1:0]        srcData,
  output logic                   rdValid,
  output logic [4:0]             rdDest,
  output logic [XLEN-1:0]        rdData,
  output logic                   excTaken,
  output logic [2:0]             excCause,
  output logic [XLEN-1:0]        excPc,
  output logic [XLEN-1:0]        excTarget,
  output logic [4:0]             raIdx,
  output logic                   intEnable,
  output logic [NUM_BP*XLEN-1:0] brkAddrs,
  output logic [NUM_WP*XLEN-1:0] wchAddrs
);

  localparam int BASE_LOW = 8;
  localparam int BASE_HI  = XLEN - BASE_LOW;

  logic              ieLive, ieExc, ieBrk;
  logic [XLEN-1:0]   maskReg, pendReg, cycReg, dbgCtlReg, txReg, rxReg;
  logic [BASE_HI-1:0] hBaseHi, dhBaseHi;

  logic [XLEN-1:0] hBase, dhBase;
  assign hBase  = {hBaseHi, {BASE_LOW{1'b0}}};
  assign dhBase = {dhBaseHi, {BASE_LOW{1'b0}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycReg <= '0;
    end else begin
      cycReg <= cycReg + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ieLive <= 1'b0;
      ieExc  <= 1'b0;
      ieBrk  <= 1'b0;
    end else if (strb.excEn) begin
      if (strb.excDebug) ieBrk <= ieLive;
      else               ieExc <= ieLive;
      ieLive <= 1'b0;
    end else if (strb.wrEn && strb.wrSel == REG_ENABLE) begin
      {ieBrk, ieExc, ieLive} <= srcData[2:0];
    end else if (strb.retExc) begin
      ieLive <= ieExc;
    end else if (strb.retBrk) begin
      ieLive <= ieBrk;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg   <= '0;
      pendReg   <= '0;
      dbgCtlReg <= '0;
      txReg     <= '0;
      rxReg     <= '0;
      hBaseHi   <= '0;
      dhBaseHi  <= '0;
    end else if (strb.wrEn) begin
      case (strb.wrSel)
        REG_MASK:   maskReg   <= srcData;
        REG_PEND:   pendReg   <= srcData;
        REG_DBGCTL: dbgCtlReg <= srcData;
        REG_CHANTX: txReg     <= srcData;
        REG_CHANRX: rxReg     <= srcData;
        REG_HBASE:  hBaseHi   <= srcData[XLEN-1:BASE_LOW];
        REG_DHBASE: dhBaseHi  <= srcData[XLEN-1:BASE_LOW];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brkAddrs <= '0;
      wchAddrs <= '0;
    end else if (strb.wrEn) begin
      for (int i = 0; i < NUM_BP; i++) begin
        if (strb.wrSel == REG_BRK0 + 5'(i)) brkAddrs[i*XLEN +: XLEN] <= srcData;
      end
      for (int j = 0; j < NUM_WP; j++) begin
        if (strb.wrSel == REG_WCH0 + 5'(j)) wchAddrs[j*XLEN +: XLEN] <= srcData;
      end
    end
  end

  logic [XLEN-1:0] rdMux;
  always_comb begin
    case (strb.rdSel)
      REG_ENABLE: rdMux = {29'd0, ieBrk, ieExc, ieLive};
      REG_MASK:   rdMux = maskReg;
      REG_PEND:   rdMux = pendReg;
      REG_CYCLES: rdMux = cycReg;
      REG_CONFIG: rdMux = CFG_VALUE;
      REG_HBASE:  rdMux = hBase;
      REG_DBGCTL: rdMux = dbgCtlReg;
      REG_DHBASE: rdMux = dhBase;
      REG_CHANTX: rdMux = txReg;
      REG_CHANRX: rdMux = rxReg;
      default:    rdMux = '0;
    endcase
  end

  logic [XLEN-1:0] trapBase;
  assign trapBase = strb.excDebug ? dhBase : hBase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid   <= 1'b0;
      rdDest    <= '0;
      rdData    <= '0;
      excTaken  <= 1'b0;
      excCause  <= '0;
      excPc     <= '0;
      excTarget <= '0;
      raIdx     <= '0;
    end else begin
      rdValid  <= strb.rdEn;
      excTaken <= strb.excEn;
      if (strb.rdEn) begin
        rdDest <= strb.rdDest;
        rdData <= rdMux;
      end
      if (strb.excEn) begin
        excCause  <= strb.excCause;
        excPc     <= instPc;
        excTarget <= trapBase + {{(XLEN-8){1'b0}}, strb.excCause, 5'd0};
        raIdx     <= strb.excDebug ? 5'd31 : 5'd30;
      end
    end
  end

  assign intEnable = ieLive;

endmodule

// File: rtl/csr_exc_unit.sv
module csr_exc_unit
  import csr_exc_pkg::*;
#(
  parameter int NUM_BP     = 2,
  parameter int NUM_WP     = 1,
  parameter bit FEAT_MUL   = 1'b1,
  parameter bit FEAT_DIV   = 1'b1,
  parameter bit FEAT_SHIFT = 1'b1,
  parameter bit FEAT_SEXT  = 1'b0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   instValid,
  input  logic [31:0]            instWord,
  input  logic [31:0]            instPc,
  input  logic [31:0]            srcData,
  input  logic                   excIllegal,
  input  logic                   excDivZero,
  input  logic                   retExc,
  input  logic                   retBrk,
  output logic                   rdValid,
  output logic [4:0]             rdDest,
  output logic [31:0]            rdData,
  output logic                   excTaken,
  output logic [2:0]             excCause,
  output logic [31:0]            excPc,
  output logic [31:0]            excTarget,
  output logic [4:0]             raIdx,
  output logic                   intEnable,
  output logic [NUM_BP*32-1:0]   brkAddrs,
  output logic [NUM_WP*32-1:0]   wchAddrs
);

  localparam logic [31:0] CFG_VALUE = {20'd0, 4'(NUM_WP), 4'(NUM_BP),
                                       FEAT_SEXT, FEAT_SHIFT, FEAT_DIV, FEAT_MUL};

  ctrlStrobe_t strb;

  csr_exc_ctrl #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP)) ctrl_i (
    .instValid (instValid),
    .instWord  (instWord),
    .excIllegal(excIllegal),
    .excDivZero(excDivZero),
    .retExc    (retExc),
    .retBrk    (retBrk),
    .strb      (strb)
  );

  csr_exc_dp #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP), .CFG_VALUE(CFG_VALUE)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .instPc   (instPc),
    .srcData  (srcData),
    .rdValid  (rdValid),
    .rdDest   (rdDest),
    .rdData   (rdData),
    .excTaken (excTaken),
    .excCause (excCause),
    .excPc    (excPc),
    .excTarget(excTarget),
    .raIdx    (raIdx),
    .intEnable(intEnable),
    .brkAddrs (brkAddrs),
    .wchAddrs (wchAddrs)
  );

endmodule

// File: rtl/csr_exc_chk.sv
module csr_exc_chk (
  input logic        clk,
  input logic        rstN,
  input logic        instValid,
  input logic [31:0] instWord,
  input logic [31:0] srcData,
  input logic        excIllegal,
  input logic        excDivZero,
  input logic        rdValid,
  input logic        excTaken,
  input logic [2:0]  excCause,
  input logic [31:0] excTarget,
  input logic [4:0]  raIdx,
  input logic        intEnable
);

  logic pastOk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  logic enableWrite;
  assign enableWrite = instValid && (instWord[31:26] == 6'd52) &&
                       (instWord[25:21] == 5'd0) && !excIllegal && !excDivZero;

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |-> (!rdValid && !excTaken && !intEnable));

  a_r9_target_offset: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |-> (excTarget[4:0] == 5'd0 && excTarget[7:5] == excCause));

  a_r9_return_reg: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |-> (raIdx == ((excCause == 3'd1) ? 5'd31 : 5'd30)));

  a_r12_no_read_on_fault: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |-> !rdValid);

  a_r10_entry_clears_enable: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |-> !intEnable);

  a_r4_enable_write_visible: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(enableWrite)) |-> (intEnable == $past(srcData[0])));

endmodule

bind csr_exc_unit csr_exc_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .instValid (instValid),
  .instWord  (instWord),
  .srcData   (srcData),
  .excIllegal(excIllegal),
  .excDivZero(excDivZero),
  .rdValid   (rdValid),
  .excTaken  (excTaken),
  .excCause  (excCause),
  .excTarget (excTarget),
  .raIdx     (raIdx),
  .intEnable (intEnable)
);

// File: tb/csr_exc_unit_tb_top.sv
`timescale 1ns/1ps
module csr_exc_unit_tb_top;

  localparam int TB_BP = 2;
  localparam int TB_WP = 1;
  localparam logic [31:0] TB_CFG = {20'd0, 4'(TB_WP), 4'(TB_BP), 1'b0, 1'b1, 1'b1, 1'b1};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic [31:0] instPc = '0;
  logic [31:0] srcData = '0;
  logic        excIllegal = 1'b0;
  logic        excDivZero = 1'b0;
  logic        retExc = 1'b0;
  logic        retBrk = 1'b0;

  logic             rdValid, excTaken, intEnable;
  logic [4:0]       rdDest, raIdx;
  logic [31:0]      rdData, excPc, excTarget;
  logic [2:0]       excCause;
  logic [TB_BP*32-1:0] brkAddrs;
  logic [TB_WP*32-1:0] wchAddrs;

  csr_exc_unit #(.NUM_BP(TB_BP), .NUM_WP(TB_WP)) dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .instPc(instPc), .srcData(srcData), .excIllegal(excIllegal),
    .excDivZero(excDivZero), .retExc(retExc), .retBrk(retBrk),
    .rdValid(rdValid), .rdDest(rdDest), .rdData(rdData),
    .excTaken(excTaken), .excCause(excCause), .excPc(excPc),
    .excTarget(excTarget), .raIdx(raIdx), .intEnable(intEnable),
    .brkAddrs(brkAddrs), .wchAddrs(wchAddrs)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [4:0]  dest;
    logic [31:0] data;
    logic [2:0]  cause;
    logic [31:0] pc;
    logic [31:0] target;
    logic [4:0]  ra;
    logic [31:0] tag;
  } exp_t;

  exp_t expQ[$];
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;
  logic [31:0] curPc = 32'h100;
  logic [31:0] lastCyc = '0;

  localparam logic [1:0] K_READ = 2'd0;
  localparam logic [1:0] K_CYC  = 2'd1;
  localparam logic [1:0] K_TRAP = 2'd2;

  task automatic chk(input logic [31:0] tag, input logic [63:0] act, input logic [63:0] expv);
    nChecks++;
    if (act !== expv) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] rdWord(input logic [4:0] num, input logic [4:0] dest);
    return {6'd36, num, 5'd0, dest, 11'd0};
  endfunction
  function automatic logic [31:0] wrWord(input logic [4:0] num);
    return {6'd52, num, 5'd3, 16'd0};
  endfunction
  function automatic logic [31:0] trapWord(input logic [4:0] code);
    return {6'd43, 21'd0, code};
  endfunction

  task automatic issue(input logic [31:0] w, input logic [31:0] src, input logic ill, input logic dz);
    @(negedge clk);
    instValid = 1'b1; instWord = w; instPc = curPc; srcData = src;
    excIllegal = ill; excDivZero = dz;
    @(posedge clk); #1;
    instValid = 1'b0; instWord = '0; excIllegal = 1'b0; excDivZero = 1'b0;
    curPc = curPc + 32'd4;
  endtask

  task automatic readExp(input logic [4:0] num, input logic [4:0] dest,
                         input logic [31:0] val, input logic [31:0] tag);
    exp_t e;
    e = '0; e.kind = K_READ; e.dest = dest; e.data = val; e.tag = tag;
    expQ.push_back(e);
    issue(rdWord(num, dest), '0, 1'b0, 1'b0);
  endtask

  task automatic cycRead(input logic [31:0] delta, input logic [31:0] tag);
    exp_t e;
    e = '0; e.kind = K_CYC; e.dest = 5'd4; e.data = delta; e.tag = tag;
    expQ.push_back(e);
    issue(rdWord(5'd5, 5'd4), '0, 1'b0, 1'b0);
  endtask

  task automatic writeReg(input logic [4:0] num, input logic [31:0] val);
    issue(wrWord(num), val, 1'b0, 1'b0);
  endtask

  task automatic trapExp(input logic [31:0] w, input logic [31:0] src, input logic ill,
                         input logic dz, input logic [2:0] cause, input logic [31:0] target,
                         input logic [4:0] ra, input logic [31:0] tag);
    exp_t e;
    e = '0; e.kind = K_TRAP; e.cause = cause; e.pc = curPc; e.target = target;
    e.ra = ra; e.tag = tag;
    expQ.push_back(e);
    issue(w, src, ill, dz);
  endtask

  task automatic strobe(input logic brk);
    @(negedge clk);
    if (brk) retBrk = 1'b1; else retExc = 1'b1;
    @(posedge clk); #1;
    retBrk = 1'b0; retExc = 1'b0;
  endtask

  exp_t monItem;
  always @(negedge clk) begin
    if (rstN && !done && (rdValid || excTaken)) begin
      if (expQ.size() == 0) begin
        chk("R12", {25'd0, rdValid, excTaken, rdDest, rdData}, 64'd0);
      end else begin
        monItem = expQ.pop_front();
        case (monItem.kind)
          K_READ: chk(monItem.tag, {25'd0, rdValid, excTaken, rdDest, rdData},
                      {25'd0, 1'b1, 1'b0, monItem.dest, monItem.data});
          K_CYC: begin
            chk(monItem.tag, {62'd0, rdValid, excTaken}, {62'd0, 2'b10});
            if (monItem.data != 0) chk(monItem.tag, {32'd0, rdData}, {32'd0, lastCyc + monItem.data});
            lastCyc = rdData;
          end
          default: begin
            chk(monItem.tag, {53'd0, excTaken, rdValid, excCause, raIdx},
                {53'd0, 1'b1, 1'b0, monItem.cause, monItem.ra});
            chk(monItem.tag, {32'd0, excPc}, {32'd0, monItem.pc});
            chk(monItem.tag, {32'd0, excTarget}, {32'd0, monItem.target});
          end
        endcase
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1'b1;
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    chk("R1", {61'd0, rdValid, excTaken, intEnable}, 64'd0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk("R1", {61'd0, rdValid, excTaken, intEnable}, 64'd0);
    readExp(5'd0, 5'd1, 32'd0, "R1");

    readExp(5'd6, 5'd2, TB_CFG, "R5");
    writeReg(5'd0, 32'd1);
    chk("R4", {63'd0, intEnable}, 64'd1);
    readExp(5'd0, 5'd3, 32'd1, "R4");

    writeReg(5'd7, 32'h1234_56FF);
    readExp(5'd7, 5'd5, 32'h1234_5600, "R6");
    writeReg(5'd9, 32'hABCD_0077);
    readExp(5'd9, 5'd6, 32'hABCD_0000, "R6");
    writeReg(5'd1, 32'h0000_F0F0);
    writeReg(5'd15, 32'h5A5A_1234);
    readExp(5'd1, 5'd7, 32'h0000_F0F0, "R2");
    readExp(5'd15, 5'd8, 32'h5A5A_1234, "R2");

    writeReg(5'd6, 32'h0);
    readExp(5'd6, 5'd9, TB_CFG, "R5");
    cycRead(32'd0, "R5");
    writeReg(5'd5, 32'd5);
    cycRead(32'd2, "R5");
    cycRead(32'd1, "R5");

    readExp(5'd3, 5'd10, 32'd0, "R3");
    readExp(5'd20, 5'd11, 32'd0, "R3");

    writeReg(5'd16, 32'hAAAA_0000);
    writeReg(5'd17, 32'hBBBB_0004);
    chk("R7", brkAddrs, 64'hBBBB_0004_AAAA_0000);
    readExp(5'd16, 5'd12, 32'd0, "R3");
    trapExp(wrWord(5'd18), 32'hDEAD_0000, 1'b0, 1'b0, 3'd2, 32'h1234_5640, 5'd30, "R7");
    chk("R10", {63'd0, intEnable}, 64'd0);
    chk("R7", brkAddrs, 64'hBBBB_0004_AAAA_0000);
    readExp(5'd0, 5'd13, 32'd2, "R10");
    strobe(1'b0);
    chk("R11", {63'd0, intEnable}, 64'd1);
    readExp(5'd0, 5'd14, 32'd3, "R11");

    writeReg(5'd24, 32'hCCCC_0008);
    chk("R7", {32'd0, wchAddrs}, {32'd0, 32'hCCCC_0008});
    trapExp(wrWord(5'd25), 32'h1, 1'b0, 1'b0, 3'd2, 32'h1234_5640, 5'd30, "R7");
    strobe(1'b0);

    trapExp(trapWord(5'd7), '0, 1'b0, 1'b0, 3'd7, 32'h1234_56E0, 5'd30, "R8");
    strobe(1'b0);
    trapExp(trapWord(5'd2), '0, 1'b0, 1'b0, 3'd1, 32'hABCD_0020, 5'd31, "R9");
    chk("R10", {63'd0, intEnable}, 64'd0);
    readExp(5'd0, 5'd15, 32'd6, "R10");
    strobe(1'b1);
    chk("R11", {63'd0, intEnable}, 64'd1);
    readExp(5'd0, 5'd16, 32'd7, "R11");
    trapExp(trapWord(5'd5), '0, 1'b0, 1'b0, 3'd2, 32'h1234_5640, 5'd30, "R8");
    strobe(1'b0);

    trapExp(rdWord(5'd0, 5'd17), '0, 1'b0, 1'b1, 3'd5, 32'h1234_56A0, 5'd30, "R12");
    strobe(1'b0);
    trapExp(trapWord(5'd7), '0, 1'b1, 1'b1, 3'd2, 32'h1234_5640, 5'd30, "R12");
    strobe(1'b0);
    trapExp(wrWord(5'd7), 32'h7700_0000, 1'b1, 1'b0, 3'd2, 32'h1234_5640, 5'd30, "R12");
    readExp(5'd7, 5'd18, 32'h1234_5600, "R12");
    strobe(1'b0);

    writeReg(5'd0, 32'd0);
    chk("R4", {63'd0, intEnable}, 64'd0);
    strobe(1'b0);
    chk("R11", {63'd0, intEnable}, 64'd0);

    repeat (3) @(negedge clk);
    chk("R2", {32'd0, 32'(expQ.size())}, 64'd0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule